// File: doc/BRIEF.md
# Skip-Based Minimal RISC Core

This block is a small multi-cycle 16-bit integer processor. Its instruction set is kept just wide enough for a simple C compiler backend. It has sixteen general registers. The ALU covers add and subtract, each with or without carry, plus AND, XOR and a logical shift right by one. The set also has an 8-bit sign-extended constant load, register-indirect load and store, one jump-and-link and four skip-next tests. There are no branch instructions and no condition flags beyond the carry bit. Compiled code builds every conditional transfer from a skip followed by a jump-and-link.

Instructions come from a synchronous instruction memory port and data moves over a synchronous data memory port. Each instruction takes a fetch cycle and an execute cycle, and a load takes one more cycle to write back. A level interrupt request is sampled at a fetch boundary. When it is taken, the core executes an all-zero word in place of the fetched one. That word decodes as a jump-and-link through r0, with the return address saved in r14.

Top module: `rcore_top`

## Requirements
- R1: After reset the first fetch address is 0, interrupts are disabled, and every register and the carry bit read as zero, even when a previous program left them non-zero.
- R2: An instruction word has opcode in [15:12], rd in [11:8], rs in [7:4] and rt in [3:0]. Opcode 1 (constant load) writes the sign-extended immediate in [7:0] into rd.
- R3: Opcodes 2/3/4/5 compute rs+rt, rs+rt+C, rs-rt and rs+~rt+C into rd. The carry bit takes the carry out of the 17-bit sum, so subtract sets carry to 1 when there is no borrow.
- R4: Opcode 6 is AND, 7 is XOR, and 8 is shift right by one of rs with a zero MSB. These three operations and all other non-arithmetic instructions leave the carry bit unchanged.
- R5: Opcode 9 loads the data word at address rs into rd. Opcode 10 stores rt to the data address held in rs.
- R6: Opcode 0 writes the address of the next instruction into register (rd XOR 14) and sets the program counter to rs.
- R7: Opcode 11 tests rs with condition code [3:0]: 0 zero, 1 nonzero, 2 negative (bit 15 set), 3 non-negative. When the test holds, the next instruction is skipped.
- R8: A skipped instruction is fetched, but none of its register, carry, memory or program-counter effects take place. Execution continues at the instruction after it.
- R9: An interrupt request is ignored while interrupts are disabled. Executing a jump-and-link whose rs is r14 enables them.
- R10: A taken interrupt runs the all-zero word instead of the fetched instruction. It saves the displaced instruction's address in r14, jumps to the address in r0, disables interrupts and pulses the acknowledge output for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| imem_addr | output | 16 | Instruction fetch address (program counter) |
| imem_rdata | input | 16 | Instruction word, valid one cycle after the address |
| dmem_addr | output | 16 | Data memory address |
| dmem_wdata | output | 16 | Data memory write value |
| dmem_we | output | 1 | Data memory write strobe |
| dmem_rdata | input | 16 | Data memory read value, valid one cycle after the address |
| irq | input | 1 | Level-sensitive interrupt request |
| irq_ack | output | 1 | One-cycle pulse when an interrupt is taken |

## Verification
The bench checks the skipped-instruction corner cases: a skipped store, a skipped load and a skipped jump-and-link. A core that only gated register writes would corrupt memory or restart the program. The eight skip tests are accumulated into one bit pattern, so swapping a single condition or testing the wrong sign bit changes a known bit. Carry chains are checked at the 16-bit wrap in both directions and with carry set before the logic operations; a core that updated carry on AND, XOR or shift would leave the wrong value behind. The interrupt tests check three more mistakes. A core that took the request before enabling would return to the wrong address. A core that failed to clear the enable would re-enter the handler while the request is still held. A core that linked PC+1 on injection would lose the displaced instruction.

// File: rtl/rcore_pkg.sv
package rcore_pkg;
  localparam int INSN_W = 16;
  localparam int REG_N  = 16;
  localparam int RIDX_W = 4;

  localparam logic [RIDX_W-1:0] LINK_FLIP = 4'hE;
  localparam logic [RIDX_W-1:0] RET_REG   = 4'hE;

  typedef enum logic [3:0] {
    OP_JAL = 4'h0, OP_LDC = 4'h1, OP_ADD = 4'h2, OP_ADC = 4'h3,
    OP_SUB = 4'h4, OP_SBC = 4'h5, OP_AND = 4'h6, OP_XOR = 4'h7,
    OP_SRL = 4'h8, OP_LD  = 4'h9, OP_ST  = 4'hA, OP_SKP = 4'hB
  } opcode_t;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_XOR, ALU_SRL
  } alu_op_t;

  typedef enum logic [1:0] {
    ST_FETCH, ST_EXEC, ST_LOAD
  } state_t;
endpackage

// File: rtl/rcore_regfile.sv
module rcore_regfile #(
  parameter int W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [rcore_pkg::RIDX_W-1:0] waddr,
  input  logic [W-1:0]                wdata,
  input  logic [rcore_pkg::RIDX_W-1:0] raddr_a,
  input  logic [rcore_pkg::RIDX_W-1:0] raddr_b,
  output logic [W-1:0]                rdata_a,
  output logic [W-1:0]                rdata_b
);
  import rcore_pkg::*;

  logic [W-1:0] regs [REG_N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < REG_N; i++) regs[i] <= '0;
    end else if (we) begin
      regs[waddr] <= wdata;
    end
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];
endmodule

// File: rtl/rcore_alu.sv
module rcore_alu #(
  parameter int W = 16
) (
  input  rcore_pkg::alu_op_t op,
  input  logic [W-1:0]       a,
  input  logic [W-1:0]       b,
  input  logic               cin,
  output logic [W-1:0]       res,
  output logic               cout
);
  import rcore_pkg::*;

  logic [W:0] sum;

  always_comb begin
    sum  = '0;
    res  = '0;
    cout = 1'b0;
    case (op)
      ALU_ADD: begin
        sum  = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
        res  = sum[W-1:0];
        cout = sum[W];
      end
      ALU_SUB: begin
        sum  = {1'b0, a} + {1'b0, ~b} + {{W{1'b0}}, cin};
        res  = sum[W-1:0];
        cout = sum[W];
      end
      ALU_AND: res = a & b;
      ALU_XOR: res = a ^ b;
      ALU_SRL: res = {1'b0, a[W-1:1]};
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/rcore_skip.sv
module rcore_skip #(
  parameter int W = 16
) (
  input  logic [3:0]   cond,
  input  logic [W-1:0] val,
  output logic         hit
);
  always_comb begin
    case (cond)
      4'd0:    hit = (val == '0);
      4'd1:    hit = (val != '0);
      4'd2:    hit = val[W-1];
      4'd3:    hit = ~val[W-1];
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/rcore_top.sv
module rcore_top #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] imem_addr,
  input  logic [15:0]  imem_rdata,
  output logic [W-1:0] dmem_addr,
  output logic [W-1:0] dmem_wdata,
  output logic         dmem_we,
  input  logic [W-1:0] dmem_rdata,
  input  logic         irq,
  output logic         irq_ack
);
  import rcore_pkg::*;

  localparam logic [W-1:0] ONE = W'(1);

  // reset: asynchronous assert, synchronous release
  logic rst_s1, rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_ns, rst_s1} <= 2'b00;
    else        {rst_ns, rst_s1} <= {rst_s1, 1'b1};
  end

  state_t              state_q, state_d;
  logic [W-1:0]        pc_q, pc_d;
  logic                carry_q, carry_d;
  logic                ie_q, ie_d;
  logic                skip_q, skip_d;
  logic                take_q, take_d;
  logic [RIDX_W-1:0]   ldrd_q, ldrd_d;

  logic [INSN_W-1:0]   ir;
  opcode_t             op;
  logic [RIDX_W-1:0]   f_rd, f_rs, f_rt;
  logic [W-1:0]        va, vb;
  logic                rf_we;
  logic [RIDX_W-1:0]   rf_waddr;
  logic [W-1:0]        rf_wdata;
  alu_op_t             alu_op;
  logic                alu_cin, alu_cout, skip_hit;
  logic [W-1:0]        alu_res;

  assign ir   = take_q ? '0 : imem_rdata;
  assign op   = opcode_t'(ir[15:12]);
  assign f_rd = ir[11:8];
  assign f_rs = ir[7:4];
  assign f_rt = ir[3:0];
  assign imem_addr = pc_q;

  rcore_regfile #(.W(W)) u_rf (
    .clk(clk), .rst_n(rst_ns), .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
    .raddr_a(f_rs), .raddr_b(f_rt), .rdata_a(va), .rdata_b(vb)
  );

  rcore_alu #(.W(W)) u_alu (
    .op(alu_op), .a(va), .b(vb), .cin(alu_cin), .res(alu_res), .cout(alu_cout)
  );

  rcore_skip #(.W(W)) u_skip (.cond(f_rt), .val(va), .hit(skip_hit));

  always_comb begin
    alu_op  = ALU_ADD;
    alu_cin = 1'b0;
    case (op)
      OP_ADC: alu_cin = carry_q;
      OP_SUB: begin alu_op = ALU_SUB; alu_cin = 1'b1;    end
      OP_SBC: begin alu_op = ALU_SUB; alu_cin = carry_q; end
      OP_AND: alu_op = ALU_AND;
      OP_XOR: alu_op = ALU_XOR;
      OP_SRL: alu_op = ALU_SRL;
      default: ;
    endcase
  end

  always_comb begin
    state_d    = state_q;
    pc_d       = pc_q;
    carry_d    = carry_q;
    ie_d       = ie_q;
    skip_d     = skip_q;
    take_d     = take_q;
    ldrd_d     = ldrd_q;
    rf_we      = 1'b0;
    rf_waddr   = f_rd;
    rf_wdata   = alu_res;
    dmem_we    = 1'b0;
    dmem_addr  = va;
    dmem_wdata = vb;
    irq_ack    = 1'b0;
    case (state_q)
      ST_FETCH: begin
        state_d = ST_EXEC;
        if (irq && ie_q && !skip_q) begin
          take_d = 1'b1;
          ie_d   = 1'b0;
        end
      end
      ST_EXEC: begin
        state_d = ST_FETCH;
        take_d  = 1'b0;
        skip_d  = 1'b0;
        pc_d    = pc_q + ONE;
        irq_ack = take_q;
        if (!skip_q) begin
          case (op)
            OP_JAL: begin
              rf_we    = 1'b1;
              rf_waddr = f_rd ^ LINK_FLIP;
              rf_wdata = take_q ? pc_q : pc_q + ONE;
              pc_d     = va;
              if (f_rs == RET_REG) ie_d = 1'b1;
            end
            OP_LDC: begin
              rf_we    = 1'b1;
              rf_wdata = {{(W-8){ir[7]}}, ir[7:0]};
            end
            OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
              rf_we   = 1'b1;
              carry_d = alu_cout;
            end
            OP_AND, OP_XOR, OP_SRL: rf_we = 1'b1;
            OP_LD: begin
              ldrd_d  = f_rd;
              state_d = ST_LOAD;
            end
            OP_ST:  dmem_we = 1'b1;
            OP_SKP: skip_d  = skip_hit;
            default: ;
          endcase
        end
      end
      ST_LOAD: begin
        state_d  = ST_FETCH;
        rf_we    = 1'b1;
        rf_waddr = ldrd_q;
        rf_wdata = dmem_rdata;
      end
      default: state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      state_q <= ST_FETCH;
      pc_q    <= '0;
      carry_q <= 1'b0;
      ie_q    <= 1'b0;
      skip_q  <= 1'b0;
      take_q  <= 1'b0;
      ldrd_q  <= '0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      carry_q <= carry_d;
      ie_q    <= ie_d;
      skip_q  <= skip_d;
      take_q  <= take_d;
      ldrd_q  <= ldrd_d;
    end
  end

  // R10
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    irq_ack |=> !irq_ack);

  // R10
  ack_ie_off_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    irq_ack |-> !ie_q);

  // R9
  ack_needs_ie_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    irq_ack |-> $past(ie_q));

  // R8
  skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (state_q == ST_EXEC && skip_q) |-> (!dmem_we && !rf_we));

  // R8
  skip_no_load_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (state_q == ST_EXEC && skip_q) |=> state_q == ST_FETCH);

  // R4
  carry_hold_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (state_q == ST_EXEC && (skip_q || !(op inside {OP_ADD, OP_ADC, OP_SUB, OP_SBC})))
      |=> $stable(carry_q));

  // R4
  srl_msb_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (state_q == ST_EXEC && !skip_q && op == OP_SRL) |-> !rf_wdata[W-1]);
endmodule

// File: tb/rcore_top_tb.sv
module rcore_top_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] imem_addr, imem_q, dmem_addr, dmem_wdata, dmem_q;
  logic        dmem_we, irq, irq_ack;

  logic [15:0] imem [64];
  logic [15:0] dmem [128];

  int nchk = 0;
  int nfail = 0;
  int acks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rcore_top u_dut (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_q),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_rdata(dmem_q), .irq(irq), .irq_ack(irq_ack)
  );

  always @(posedge clk) begin
    imem_q <= imem[imem_addr[5:0]];
    if (dmem_we) dmem[dmem_addr[6:0]] <= dmem_wdata;
    dmem_q <= dmem[dmem_addr[6:0]];
  end

  always @(negedge clk) if (rst_n && irq_ack) acks++;

  // {opcode, a, b, carry before, expected result, expected carry}
  localparam logic [53:0] VEC [12] = '{
    {4'h2, 16'h1234, 16'h0F0F, 1'b1, 16'h2143, 1'b0},
    {4'h2, 16'hFFFF, 16'h0001, 1'b0, 16'h0000, 1'b1},
    {4'h3, 16'h00FF, 16'h0001, 1'b1, 16'h0101, 1'b0},
    {4'h3, 16'hFFFF, 16'h0000, 1'b1, 16'h0000, 1'b1},
    {4'h4, 16'h0005, 16'h0003, 1'b0, 16'h0002, 1'b1},
    {4'h4, 16'h0003, 16'h0005, 1'b1, 16'hFFFE, 1'b0},
    {4'h5, 16'h0010, 16'h0001, 1'b0, 16'h000E, 1'b1},
    {4'h5, 16'h0010, 16'h0001, 1'b1, 16'h000F, 1'b1},
    {4'h6, 16'hF0F0, 16'h3C3C, 1'b1, 16'h3030, 1'b1},
    {4'h7, 16'hF0F0, 16'h3C3C, 1'b0, 16'hCCCC, 1'b0},
    {4'h8, 16'h8001, 16'hFFFF, 1'b1, 16'h4000, 1'b1},
    {4'h5, 16'h0000, 16'h0000, 1'b0, 16'hFFFF, 1'b0}
  };

  function automatic logic [15:0] ins(input logic [3:0] op, input logic [3:0] d,
                                      input logic [3:0] s, input logic [3:0] t);
    return {op, d, s, t};
  endfunction
  function automatic logic [15:0] ldc(input logic [3:0] d, input logic [7:0] imm);
    return {4'h1, d, imm};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) imem[i] = 16'h0000;
    for (int i = 0; i < 128; i++) dmem[i] = 16'h0000;
  endtask

  task automatic put_halt(input int at);
    imem[at]   = ldc(4'd13, 8'(at + 1));
    imem[at+1] = ins(4'h0, 4'd1, 4'd13, 4'd0);
  endtask

  task automatic restart(input int cycles);
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (cycles) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    irq   = 1'b0;
    clear_mem();
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R1 reset state at the ports
    check("R1 fetch addr", imem_addr, 16'h0000);
    check("R1 ack idle", {15'd0, irq_ack}, 16'h0000);
    check("R1 no store", {15'd0, dmem_we}, 16'h0000);

    // arithmetic and logic vectors
    for (int i = 0; i < 12; i++) begin
      logic [3:0]  vop;
      logic [15:0] va, vb, ex;
      logic        vc, ec;
      {vop, va, vb, vc, ex, ec} = VEC[i];
      clear_mem();
      dmem[16] = va;
      dmem[17] = vb;
      imem[0]  = ldc(4'd10, 8'h10);
      imem[1]  = ldc(4'd11, 8'h11);
      imem[2]  = ins(4'h9, 4'd1, 4'd10, 4'd0);
      imem[3]  = ins(4'h9, 4'd2, 4'd11, 4'd0);
      imem[4]  = vc ? ins(4'h4, 4'd3, 4'd5, 4'd5) : ins(4'h2, 4'd3, 4'd5, 4'd5);
      imem[5]  = ins(vop, 4'd6, 4'd1, 4'd2);
      imem[6]  = ldc(4'd12, 8'h20);
      imem[7]  = ins(4'hA, 4'd0, 4'd12, 4'd6);
      imem[8]  = ins(4'h3, 4'd7, 4'd5, 4'd5);
      imem[9]  = ldc(4'd12, 8'h21);
      imem[10] = ins(4'hA, 4'd0, 4'd12, 4'd7);
      put_halt(11);
      restart(70);
      if (vop <= 4'h5) begin
        check($sformatf("R3 result vec%0d", i), dmem[32], ex);
        check($sformatf("R3 carry vec%0d", i), dmem[33], {15'd0, ec});
      end else begin
        check($sformatf("R4 result vec%0d", i), dmem[32], ex);
        check($sformatf("R4 carry vec%0d", i), dmem[33], {15'd0, ec});
      end
    end

    // R1: carry and registers left non-zero are cleared by reset
    clear_mem();
    imem[0] = ldc(4'd1, 8'h33);
    imem[1] = ins(4'h4, 4'd3, 4'd5, 4'd5);
    put_halt(2);
    restart(20);
    imem[0] = ins(4'h3, 4'd2, 4'd1, 4'd5);
    imem[1] = ldc(4'd9, 8'h50);
    imem[2] = ins(4'hA, 4'd0, 4'd9, 4'd2);
    put_halt(3);
    dmem[80] = 16'hBEEF;
    restart(30);
    check("R1 regs and carry cleared", dmem[80], 16'h0000);

    // R6 jump-and-link, R2 constant load, R5 load/store
    clear_mem();
    dmem[96]  = 16'hAAAA;
    dmem[112] = 16'h1357;
    imem[0]  = ldc(4'd2, 8'd6);
    imem[1]  = ins(4'h0, 4'd3, 4'd2, 4'd0);
    imem[2]  = ldc(4'd9, 8'h60);
    imem[3]  = ins(4'hA, 4'd0, 4'd9, 4'd2);
    imem[6]  = ldc(4'd9, 8'h61);
    imem[7]  = ins(4'hA, 4'd0, 4'd9, 4'd13);
    imem[8]  = ldc(4'd4, 8'h80);
    imem[9]  = ldc(4'd9, 8'h62);
    imem[10] = ins(4'hA, 4'd0, 4'd9, 4'd4);
    imem[11] = ldc(4'd4, 8'h7F);
    imem[12] = ldc(4'd9, 8'h63);
    imem[13] = ins(4'hA, 4'd0, 4'd9, 4'd4);
    imem[14] = ldc(4'd1, 8'h70);
    imem[15] = ins(4'h9, 4'd2, 4'd1, 4'd0);
    imem[16] = ins(4'h2, 4'd3, 4'd2, 4'd2);
    imem[17] = ldc(4'd1, 8'h71);
    imem[18] = ins(4'hA, 4'd0, 4'd1, 4'd3);
    put_halt(19);
    restart(80);
    check("R6 link value in r13", dmem[97], 16'h0002);
    check("R6 jumped over", dmem[96], 16'hAAAA);
    check("R2 negative imm", dmem[98], 16'hFF80);
    check("R2 positive imm", dmem[99], 16'h007F);
    check("R5 load then store", dmem[113], 16'h26AE);

    // R7 skip conditions, R8 suppressed effects
    clear_mem();
    dmem[48] = 16'hDEAD;
    imem[0] = ldc(4'd1, 8'h00);
    imem[1] = ldc(4'd2, 8'hFF);
    imem[2] = ldc(4'd3, 8'h05);
    imem[3] = ldc(4'd8, 8'h01);
    imem[4] = ldc(4'd9, 8'h30);
    imem[5] = ldc(4'd6, 8'h22);
    begin
      logic [3:0] sreg [8] = '{4'd1, 4'd3, 4'd3, 4'd1, 4'd2, 4'd3, 4'd3, 4'd2};
      logic [3:0] scnd [8] = '{4'd0, 4'd0, 4'd1, 4'd1, 4'd2, 4'd2, 4'd3, 4'd3};
      for (int k = 0; k < 8; k++) begin
        imem[6+3*k] = ins(4'h2, 4'd7, 4'd7, 4'd7);
        imem[7+3*k] = ins(4'hB, 4'd0, sreg[k], scnd[k]);
        imem[8+3*k] = ins(4'h2, 4'd7, 4'd7, 4'd8);
      end
    end
    imem[30] = ins(4'hB, 4'd0, 4'd1, 4'd0);
    imem[31] = ins(4'hA, 4'd0, 4'd9, 4'd8);
    imem[32] = ins(4'hB, 4'd0, 4'd1, 4'd0);
    imem[33] = ins(4'h9, 4'd6, 4'd9, 4'd0);
    imem[34] = ins(4'hB, 4'd0, 4'd1, 4'd0);
    imem[35] = ins(4'h0, 4'd1, 4'd1, 4'd0);
    imem[36] = ldc(4'd9, 8'h31);
    imem[37] = ins(4'hA, 4'd0, 4'd9, 4'd6);
    imem[38] = ldc(4'd9, 8'h32);
    imem[39] = ins(4'hA, 4'd0, 4'd9, 4'd7);
    put_halt(40);
    restart(150);
    check("R7 skip pattern", dmem[50], 16'h0055);
    check("R8 skipped store", dmem[48], 16'hDEAD);
    check("R8 skipped load", dmem[49], 16'h0022);

    // R9 / R10 interrupts
    clear_mem();
    imem[0]  = ldc(4'd0, 8'd20);
    imem[1]  = ldc(4'd14, 8'd3);
    imem[2]  = ins(4'h0, 4'd0, 4'd14, 4'd0);
    imem[3]  = ldc(4'd5, 8'd1);
    imem[4]  = ins(4'h2, 4'd6, 4'd6, 4'd5);
    imem[5]  = ldc(4'd13, 8'd4);
    imem[6]  = ins(4'h0, 4'd2, 4'd13, 4'd0);
    imem[20] = ldc(4'd9, 8'h40);
    imem[21] = ins(4'hA, 4'd0, 4'd9, 4'd14);
    imem[22] = ldc(4'd10, 8'd1);
    imem[23] = ins(4'h2, 4'd11, 4'd11, 4'd10);
    imem[24] = ldc(4'd9, 8'h41);
    imem[25] = ins(4'hA, 4'd0, 4'd9, 4'd11);
    imem[26] = ins(4'h0, 4'd2, 4'd14, 4'd0);
    irq = 1'b1;
    acks = 0;
    restart(0);
    for (int c = 0; c < 200 && acks == 0; c++) @(negedge clk);
    repeat (6) @(negedge clk);
    irq = 1'b0;
    repeat (60) @(negedge clk);
    check("R9 return addr after enable", dmem[64], 16'h0003);
    check("R10 handler ran once", dmem[65], 16'h0001);
    check("R10 ack width and count", 16'(acks), 16'h0001);
    irq = 1'b1;
    for (int c = 0; c < 200 && acks < 2; c++) @(negedge clk);
    irq = 1'b0;
    repeat (60) @(negedge clk);
    check("R10 second entry", dmem[65], 16'h0002);
    check("R10 link in loop", {15'd0, (dmem[64] >= 16'd4 && dmem[64] <= 16'd6)}, 16'h0001);
    check("R10 second ack single", 16'(acks), 16'h0002);

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++;
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end
endmodule